// File: doc/BRIEF.md
# Hall Sensor Fault Monitor

This block watches the three digital Hall sensor lines of a six-step commutated motor and reports two kinds of sensor fault. A level fault is raised when the three lines show a combination that never occurs on a healthy rotor, all low or all high. A sequence fault is raised when two different lines change state too close together in time. On a healthy motor only one sensor changes per 60 electrical degrees, so near-simultaneous changes point to shorted lines or a damaged cell.

Each Hall line first passes through a synchroniser. A per-line edge detector then starts a pulse of `PULSE_W` clock cycles on every rising or falling change. Two pulses that are active in the same cycle mean a sequence fault. Both fault flags are sticky until the controller pulses `err_clr`, so a glitch lasting a single cycle is still visible to software. A separate output toggles once for every transition on any Hall line, which gives a tachometer-style signal.

Each pulse generator is a two-state machine. In `PG_IDLE` it waits, and the transition `start` takes it to `PG_HOLD`. In `PG_HOLD` the transition `restart` handles a new edge by reloading the counter, and the transition `expire` returns it to `PG_IDLE` once the count reaches its last value. Each fault flag is also a two-state machine. The transition `raise` takes `FL_CLEAR` to `FL_SET`. The transition `acknowledge` takes `FL_SET` back to `FL_CLEAR`, but only when a clear arrives with no new fault event in the same cycle.

Top module: `hall_fault_monitor`

## Requirements
- R1: The six patterns on `hall_in` as {H1,H2,H3} = {hall_in[2],hall_in[1],hall_in[0]} (100, 101, 001, 011, 010, 110) never set `pattern_err`.
- R2: A synchronised sample of 000 or 111 sets `pattern_err` three clock edges after the input changes.
- R3: Once set, a flag stays set until `err_clr` is high at a clock edge. A clear with no new event drops the flag at that edge.
- R4: If `err_clr` and a new fault event fall in the same cycle, the flag stays set.
- R5: Transitions on two different lines whose synchronised edges are fewer than `PULSE_W` cycles apart set `sequence_err`. This includes two lines changing in the same cycle.
- R6: Transitions on different lines spaced `PULSE_W` or more cycles apart never set `sequence_err`.
- R7: `cycle_toggle` inverts once for each single-line transition. When several lines change in the same cycle, it inverts by the parity of the number of changed lines.
- R8: A new edge on a line whose pulse is still active restarts that line's pulse for a full `PULSE_W` cycles.
- R9: After reset all outputs are 0. The level present on `hall_in` while the synchroniser fills is not treated as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Raw Hall lines: bit 2 = H1, bit 1 = H2, bit 0 = H3 |
| err_clr | input | 1 | Clears both sticky fault flags |
| pattern_err | output | 1 | Sticky invalid-level fault |
| sequence_err | output | 1 | Sticky overlapping-transition fault |
| cycle_toggle | output | 1 | Inverts on each Hall transition |

## Verification
On every cycle, the assertions check that every detected edge starts or restarts a pulse with a zeroed count. They check that a pulse ends only at its final count, and that any two overlapping pulses, or any bad level, raise the matching flag one edge later. They also check that flags hold without a clear, drop on a clear with no event, and that the toggle output follows the parity of the edges. Only the bench scenarios can show the end-to-end timing boundary, with spacing of `PULSE_W-1` against `PULSE_W`. They also show that a restarted pulse, rather than the original one, creates an overlap, and that nothing spurious appears when reset is released.

// File: rtl/hall_mon_pkg.sv
package hall_mon_pkg;

    localparam int HALL_LINES = 3;

    typedef enum logic {
        PG_IDLE,
        PG_HOLD
    } pulse_state_e;

    typedef enum logic {
        FL_CLEAR,
        FL_SET
    } flag_state_e;

    // All lines equal (all low or all high) never occurs on a healthy rotor.
    function automatic logic level_is_bad(input logic [HALL_LINES-1:0] v);
        return (&v) | (~|v);
    endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hall_edge_pulse.sv
module hall_edge_pulse
    import hall_mon_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic level,
    output logic edge_o,
    output logic pulse_o
);

    localparam int CW = (PULSE_W > 2) ? $clog2(PULSE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_W - 1);

    pulse_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          prev_q;

    // Both rising and falling changes count, once the pipeline holds real samples.
    assign edge_o = arm & (level ^ prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: start, restart, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE: if (edge_o) state_d = PG_HOLD;
            PG_HOLD: begin
                if (edge_o) begin
                    state_d = PG_HOLD;
                end else if (cnt_q == LAST) begin
                    state_d = PG_IDLE;
                end
            end
            default: state_d = PG_IDLE;
        endcase
    end

    // Width counter: reloads on each edge, clears itself at its last value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (edge_o) begin
            cnt_q <= '0;
        end else if (state_q == PG_HOLD) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pulse_o = (state_q == PG_HOLD);
    end

    p_edge_starts_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (pulse_o && cnt_q == '0));

    p_pulse_ends_at_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> ($past(cnt_q) == LAST));

    p_pulse_counts_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !edge_o && cnt_q != LAST) |=> (pulse_o && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/hall_sticky_flag.sv
module hall_sticky_flag
    import hall_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag_o
);

    flag_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: raise, acknowledge. An event in the clear cycle wins.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (evt) state_d = FL_SET;
            FL_SET:   if (clr && !evt) state_d = FL_CLEAR;
            default:  state_d = FL_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        flag_o = (state_q == FL_SET);
    end

    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_o);

    p_holds_without_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag_o);

endmodule

// File: rtl/hall_fault_monitor.sv
module hall_fault_monitor
    import hall_mon_pkg::*;
#(
    parameter int PULSE_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALL_LINES-1:0] hall_in,
    input  logic                  err_clr,
    output logic                  pattern_err,
    output logic                  sequence_err,
    output logic                  cycle_toggle
);

    // Synchroniser stages plus the edge detector's previous-sample flop.
    localparam int FILL_MAX = SYNC_STAGES + 1;
    localparam int FW       = $clog2(FILL_MAX + 1);
    localparam logic [FW-1:0] FILL_DONE = FW'(FILL_MAX);

    logic [HALL_LINES-1:0] hall_s;
    logic [HALL_LINES-1:0] edge_v;
    logic [HALL_LINES-1:0] pulse_v;
    logic [FW-1:0]         fill_q;
    logic                  settled;
    logic                  level_evt;
    logic                  overlap_evt;
    logic                  toggle_q;

    hall_sync #(
        .WIDTH (HALL_LINES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hall_in),
        .dout (hall_s)
    );

    // Hold off detection until every pipeline flop holds a real sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != FILL_DONE) begin
            fill_q <= fill_q + 1'b1;
        end
    end
    assign settled = (fill_q == FILL_DONE);

    for (genvar g = 0; g < HALL_LINES; g++) begin : g_line
        hall_edge_pulse #(
            .PULSE_W(PULSE_W)
        ) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (settled),
            .level  (hall_s[g]),
            .edge_o (edge_v[g]),
            .pulse_o(pulse_v[g])
        );
    end

    assign level_evt   = settled & level_is_bad(hall_s);
    assign overlap_evt = ($countones(pulse_v) >= 2);

    hall_sticky_flag u_level_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (level_evt),
        .clr   (err_clr),
        .flag_o(pattern_err)
    );

    hall_sticky_flag u_overlap_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (overlap_evt),
        .clr   (err_clr),
        .flag_o(sequence_err)
    );

    // Inverts by the parity of lines that changed in this cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else begin
            toggle_q <= toggle_q ^ (^edge_v);
        end
    end
    assign cycle_toggle = toggle_q;

    p_toggle_follows_edges_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (^edge_v) |=> (cycle_toggle != $past(cycle_toggle)));

    p_toggle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(^edge_v) |=> $stable(cycle_toggle));

    p_bad_level_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && level_is_bad(hall_s)) |=> pattern_err);

    p_overlap_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pulse_v) >= 2) |=> sequence_err);

    p_no_edge_before_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |-> (edge_v == '0));

endmodule

// File: tb/hall_fault_monitor_test.sv
module hall_fault_monitor_test;

    localparam int PW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b100;
    logic       err_clr = 1'b0;
    logic       pattern_err;
    logic       sequence_err;
    logic       cycle_toggle;

    int   checks = 0;
    int   errors = 0;
    logic exp_tog = 1'b0;
    bit   finished = 1'b0;

    string      q_req[$];
    logic [2:0] q_exp[$];

    always #4 clk = ~clk;

    hall_fault_monitor #(.PULSE_W(PW), .SYNC_STAGES(2)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hall_in     (hall_in),
        .err_clr     (err_clr),
        .pattern_err (pattern_err),
        .sequence_err(sequence_err),
        .cycle_toggle(cycle_toggle)
    );

    // Monitor: pops each expected item and compares it with the outputs.
    always @(negedge clk) begin
        if (q_req.size() > 0) begin
            string      r;
            logic [2:0] e;
            logic [2:0] got;
            r   = q_req.pop_front();
            e   = q_exp.pop_front();
            got = {pattern_err, sequence_err, cycle_toggle};
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s: {pat,seq,tog} actual %b expected %b", r, got, e);
            end
        end
    end

    task automatic drive(input logic [2:0] v);
        @(negedge clk);
        exp_tog = exp_tog ^ (^(hall_in ^ v));
        hall_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic pat, input logic seq);
        q_req.push_back(req);
        q_exp.push_back({pat, seq, exp_tog});
        while (q_req.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(10);
        expect_out("R9 reset, no spurious edge", 1'b0, 1'b0);

        // R1 R6 R7: forward walk, wide spacing
        drive(3'b101); idle(8); expect_out("R1 R7 step 101", 1'b0, 1'b0);
        drive(3'b001); idle(8); expect_out("R1 R7 step 001", 1'b0, 1'b0);
        drive(3'b011); idle(8); expect_out("R1 R7 step 011", 1'b0, 1'b0);
        drive(3'b010); idle(8); expect_out("R1 R7 step 010", 1'b0, 1'b0);
        drive(3'b110); idle(8); expect_out("R1 R7 step 110", 1'b0, 1'b0);
        drive(3'b100); idle(8); expect_out("R1 R7 step 100", 1'b0, 1'b0);

        // R6: reverse walk at exactly PW cycles spacing
        drive(3'b110); idle(PW - 1);
        drive(3'b010); idle(PW - 1);
        drive(3'b011); idle(PW - 1);
        drive(3'b001); idle(PW - 1);
        drive(3'b101); idle(PW - 1);
        drive(3'b100); idle(8);
        expect_out("R6 spacing PW no fault", 1'b0, 1'b0);

        // R5: spacing PW-1
        drive(3'b101); idle(PW - 2);
        drive(3'b001); idle(8);
        expect_out("R5 spacing PW-1 fault", 1'b0, 1'b1);

        // R3: sticky, then clear
        idle(20);
        expect_out("R3 flag holds", 1'b0, 1'b1);
        pulse_clear(); idle(2);
        expect_out("R3 clear drops flag", 1'b0, 1'b0);

        // R5 R7: two lines in the same cycle
        drive(3'b010); idle(8);
        expect_out("R5 R7 simultaneous change", 1'b0, 1'b1);
        pulse_clear(); idle(2);
        expect_out("R3 clear after simultaneous", 1'b0, 1'b0);

        // R8: restarted pulse on H3 overlaps a later H1 edge
        drive(3'b011); idle(2);
        drive(3'b010); idle(2);
        drive(3'b110); idle(8);
        expect_out("R8 restart extends pulse", 1'b0, 1'b1);
        pulse_clear(); idle(2);
        expect_out("R3 clear after restart", 1'b0, 1'b0);

        // R2: all high
        drive(3'b111); idle(8);
        expect_out("R2 level 111", 1'b1, 1'b0);
        drive(3'b110); idle(8);
        expect_out("R3 level flag holds", 1'b1, 1'b0);
        pulse_clear(); idle(2);
        expect_out("R3 level flag cleared", 1'b0, 1'b0);

        // R2: all low
        drive(3'b100); idle(8);
        drive(3'b000); idle(8);
        expect_out("R2 level 000", 1'b1, 1'b0);

        // R4: clear while the fault is still present
        pulse_clear(); idle(2);
        expect_out("R4 event beats clear", 1'b1, 1'b0);
        drive(3'b100); idle(8);
        pulse_clear(); idle(2);
        expect_out("R3 final clear", 1'b0, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule